// File: doc/BRIEF.md
# Decimated Repetitive Voltage Controller

This block computes a current reference from a stream of signed voltage-error samples. Two paths are summed. The first is a proportional term. The second is a repetitive term, which reaches a very large gain at every harmonic of a fundamental whose period is one trip around a delay loop.

The repetitive path does not run at the input rate. It first averages each window of `DEC` input samples into one value, so the loop only needs about one tenth of the storage. Each averaged value is added to a moving-average-filtered copy of the loop's own history. That history is held in a circular buffer that is shorter than the loop period. The buffer is shortened by the filter's group delay, so the total lag around the loop stays at exactly `PER` decimated steps. The delayed loop value is scaled by a gain to give a new target. Because the target moves in steps, a first-order hold ramps the repetitive contribution towards the target over the following window before it is added to the proportional term.

A controller core drives the block with one strobe per sample. The `enable` input switches the repetitive path on and off. While `enable` is low, only the proportional term reaches the output.

The control state machine has three states:
- `ST_OFF`: the path is disabled and held clear.
- `ST_GATHER`: input samples are collected into the current window.
- `ST_UPDATE`: the loop advances by one step.

Its transitions are:
- OFF-to-GATHER, when `enable` is high.
- GATHER-to-UPDATE, on the strobe that closes a window.
- UPDATE-to-GATHER, always after one cycle.
- Any state to OFF, whenever `enable` is low.

Top module: `rptv_ctrl`

## Requirements
- R1: `ref_out` is 0 after reset. It changes only in the clock that captures a `smp_valid` strobe, and holds its value in every other clock.
- R2: On a strobe, `ref_out` = clamp16(((kp·err_in) >>> 12) + H). `kp` is a signed Q4.12 value. H is the interpolated repetitive value of R6, and H is 0 when `enable` is low.
- R3: While enabled, the strobes are grouped into windows of DEC=10, counted from the first strobe after `enable` rises. The window mean is (S·6554) >>> 16, where S is the exact sum of the window's 10 samples.
- R4: When a window closes, the loop value is v[n] = clamp24(mean + ((v[n−79] + v[n−80] + v[n−81])·21845 >>> 16)). Every loop value earlier than the latest enable counts as 0.
- R5: In the same step, the repetitive target is clamp16((krep·v[n−80]) >>> 12). `krep` is a signed Q4.12 value.
- R6: At each update, slope = ((target − H)·6554) >>> 16. At every following enabled strobe, H becomes clamp18(H + slope) before it is used in R2.
- R7: `kp_in` and `krep_in` are sampled only at the strobe that opens a window. Changes at later strobes of the same window have no effect until the next window.
- R8: A clock with `enable` low clears the loop history, the buffer pointer, the window count, H and the slope. It also forces H to 0, so that the output follows R2 with proportional action only. While disabled, every strobe samples the coefficients.
- R9: The output sum saturates at −32768 and 32767 and never wraps.
- R10: Strobes are at least two clocks apart. The loop update takes place in the clock after the strobe that closes a window.
- R11: The update state lasts exactly one clock and is always followed by the gather state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Enables the repetitive path; low clears it |
| smp_valid | input | 1 | One-clock strobe marking a new error sample |
| err_in | input | 16 | Signed voltage error sample |
| kp_in | input | 16 | Proportional gain, signed Q4.12 |
| krep_in | input | 16 | Repetitive gain, signed Q4.12 |
| ref_out | output | 16 | Signed current reference |

## Verification
With the repetitive path disabled, a set of gain and error pairs includes both saturation extremes. This isolates the proportional term and its clamp. A periodic triangle with narrow spikes, run over three loop periods, separates a correct 80-step loop lag and a correct filter centre from designs that are off by one, because the loop growth only lines up when every window maps to the same history slot. A gain change in the middle of a window shows whether the coefficients are latched at the window boundary. A disable followed by a restart with a large constant error shows that the history really is cleared, and drives the output into saturation through the interpolator.

// File: rtl/rptv_pkg.sv
package rptv_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_GATHER = 2'd1,
        ST_UPDATE = 2'd2
    } rptv_state_e;

    localparam int WIDE = 64;
    typedef logic signed [WIDE-1:0] wide_t;

    // Saturate a wide value to the signed range of w bits.
    function automatic wide_t clamp(input wide_t x, input int w);
        wide_t hi;
        wide_t lo;
        hi = (wide_t'(1) <<< (w - 1)) - wide_t'(1);
        lo = -(wide_t'(1) <<< (w - 1));
        if (x > hi) return hi;
        if (x < lo) return lo;
        return x;
    endfunction

    // Rounded reciprocal of div scaled by 2**sh.
    function automatic int recip(input int div, input int sh);
        return ((1 << sh) + div / 2) / div;
    endfunction

endpackage

// File: rtl/rptv_window_avg.sv
module rptv_window_avg
    import rptv_pkg::*;
#(
    parameter int DW  = 16,
    parameter int DEC = 10,
    parameter int RSH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 take,
    input  logic                 first,
    input  logic signed [DW-1:0] err,
    output logic signed [DW-1:0] mean
);

    localparam int    BW  = DW + $clog2(DEC) + 1;
    localparam wide_t RCP = wide_t'(recip(DEC, RSH));

    logic signed [BW-1:0] box_q;

    function automatic logic signed [DW-1:0] to_dw(input wide_t x);
        wide_t c;
        c = clamp(x, DW);
        return c[DW-1:0];
    endfunction

    // Boxcar sum, restarted by the first sample of each window.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            box_q <= '0;
        end else if (clr) begin
            box_q <= '0;
        end else if (take) begin
            box_q <= first ? BW'(err) : box_q + BW'(err);
        end
    end

    // Mean through a constant reciprocal multiply.
    always_comb begin
        mean = to_dw((wide_t'(box_q) * RCP) >>> RSH);
    end

endmodule

// File: rtl/rptv_loop.sv
module rptv_loop
    import rptv_pkg::*;
#(
    parameter int DW      = 16,
    parameter int AW      = 24,
    parameter int CW      = 16,
    parameter int FW      = 12,
    parameter int PER     = 80,
    parameter int MA_TAPS = 3,
    parameter int RSH     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 step,
    input  logic signed [DW-1:0] mean,
    input  logic signed [CW-1:0] krep,
    output logic signed [DW-1:0] target
);

    localparam int    HALF = (MA_TAPS - 1) / 2;
    localparam int    DLEN = PER - HALF;
    localparam int    NT   = MA_TAPS - 1;
    localparam int    PW   = (DLEN > 1) ? $clog2(DLEN) : 1;
    localparam wide_t RMA  = wide_t'(recip(MA_TAPS, RSH));

    logic signed [AW-1:0] line_q [DLEN];
    logic [PW-1:0]        ptr_q;
    logic signed [AW-1:0] rd;
    logic signed [AW-1:0] center;
    logic signed [AW-1:0] vnew;
    wide_t                tap_sum;

    function automatic logic signed [AW-1:0] to_aw(input wide_t x);
        wide_t c;
        c = clamp(x, AW);
        return c[AW-1:0];
    endfunction

    function automatic logic signed [DW-1:0] to_dw(input wide_t x);
        wide_t c;
        c = clamp(x, DW);
        return c[DW-1:0];
    endfunction

    assign rd = line_q[ptr_q];

    // Moving-average taps trailing the buffer read.
    generate
        if (NT > 0) begin : g_ma
            logic signed [AW-1:0] tap_q [NT];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < NT; i++) tap_q[i] <= '0;
                end else if (clr) begin
                    for (int i = 0; i < NT; i++) tap_q[i] <= '0;
                end else if (step) begin
                    tap_q[0] <= rd;
                    for (int i = 1; i < NT; i++) tap_q[i] <= tap_q[i-1];
                end
            end

            always_comb begin
                tap_sum = wide_t'(rd);
                for (int i = 0; i < NT; i++) tap_sum = tap_sum + wide_t'(tap_q[i]);
            end

            assign center = tap_q[HALF-1];
        end else begin : g_pass
            assign tap_sum = wide_t'(rd);
            assign center  = rd;
        end
    endgenerate

    // Positive feedback: new loop value from window mean and filtered history.
    always_comb begin
        vnew   = to_aw(wide_t'(mean) + ((tap_sum * RMA) >>> RSH));
        target = to_dw((wide_t'(krep) * wide_t'(center)) >>> FW);
    end

    // Circular delay line, shortened by the filter group delay.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DLEN; i++) line_q[i] <= '0;
            ptr_q <= '0;
        end else if (clr) begin
            for (int i = 0; i < DLEN; i++) line_q[i] <= '0;
            ptr_q <= '0;
        end else if (step) begin
            line_q[ptr_q] <= vnew;
            ptr_q <= (ptr_q == PW'(DLEN - 1)) ? '0 : ptr_q + PW'(1);
        end
    end

endmodule

// File: rtl/rptv_foh.sv
module rptv_foh
    import rptv_pkg::*;
#(
    parameter int DW  = 16,
    parameter int HW  = 18,
    parameter int DEC = 10,
    parameter int RSH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 load,
    input  logic signed [DW-1:0] target,
    input  logic                 advance,
    output logic signed [HW-1:0] hold_nx
);

    localparam wide_t RCP = wide_t'(recip(DEC, RSH));

    logic signed [HW-1:0] hold_q;
    logic signed [HW-1:0] slope_q;
    logic signed [HW-1:0] slope_d;

    function automatic logic signed [HW-1:0] to_hw(input wide_t x);
        wide_t c;
        c = clamp(x, HW);
        return c[HW-1:0];
    endfunction

    always_comb begin
        hold_nx = to_hw(wide_t'(hold_q) + wide_t'(slope_q));
        slope_d = to_hw(((wide_t'(target) - wide_t'(hold_q)) * RCP) >>> RSH);
    end

    // Linear ramp from the current value towards each new target.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            slope_q <= '0;
        end else if (clr) begin
            hold_q  <= '0;
            slope_q <= '0;
        end else begin
            if (advance) hold_q  <= hold_nx;
            if (load)    slope_q <= slope_d;
        end
    end

endmodule

// File: rtl/rptv_ctrl.sv
module rptv_ctrl
    import rptv_pkg::*;
#(
    parameter int DW      = 16,
    parameter int CW      = 16,
    parameter int FW      = 12,
    parameter int AW      = 24,
    parameter int DEC     = 10,
    parameter int PER     = 80,
    parameter int MA_TAPS = 3,
    parameter int RSH     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] err_in,
    input  logic signed [CW-1:0] kp_in,
    input  logic signed [CW-1:0] krep_in,
    output logic signed [DW-1:0] ref_out
);

    localparam int KW = (DEC > 1) ? $clog2(DEC) : 1;
    localparam int HW = DW + 2;

    rptv_state_e          state_q;
    rptv_state_e          state_d;
    logic [KW-1:0]        win_q;
    logic [KW-1:0]        win_eff;
    logic                 accept;
    logic                 step;
    logic                 clr;
    logic                 first;
    logic                 last;
    logic signed [CW-1:0] kp_q;
    logic signed [CW-1:0] krep_q;
    logic signed [CW-1:0] kp_use;
    logic signed [DW-1:0] mean;
    logic signed [DW-1:0] target;
    logic signed [HW-1:0] hold_nx;
    logic signed [DW-1:0] ref_d;

    function automatic logic signed [DW-1:0] to_dw(input wide_t x);
        wide_t c;
        c = clamp(x, DW);
        return c[DW-1:0];
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF, ST_GATHER: state_d = (accept && last) ? ST_UPDATE : ST_GATHER;
                ST_UPDATE:         state_d = ST_GATHER;
                default:           state_d = ST_OFF;
            endcase
        end
    end

    // State outputs
    always_comb begin
        clr     = !enable;
        accept  = smp_valid && enable;
        step    = enable && (state_q == ST_UPDATE);
        win_eff = enable ? win_q : '0;
        first   = (win_eff == '0);
        last    = (win_q == KW'(DEC - 1));
    end

    // Window position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (clr) begin
            win_q <= '0;
        end else if (accept) begin
            win_q <= last ? '0 : win_q + KW'(1);
        end
    end

    // Coefficients taken only at the opening strobe of a window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kp_q   <= '0;
            krep_q <= '0;
        end else if (smp_valid && first) begin
            kp_q   <= kp_in;
            krep_q <= krep_in;
        end
    end

    assign kp_use = first ? kp_in : kp_q;

    rptv_window_avg #(
        .DW (DW),
        .DEC(DEC),
        .RSH(RSH)
    ) u_avg (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .take (accept),
        .first(first),
        .err  (err_in),
        .mean (mean)
    );

    rptv_loop #(
        .DW     (DW),
        .AW     (AW),
        .CW     (CW),
        .FW     (FW),
        .PER    (PER),
        .MA_TAPS(MA_TAPS),
        .RSH    (RSH)
    ) u_loop (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (step),
        .mean  (mean),
        .krep  (krep_q),
        .target(target)
    );

    rptv_foh #(
        .DW (DW),
        .HW (HW),
        .DEC(DEC),
        .RSH(RSH)
    ) u_foh (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .load   (step),
        .target (target),
        .advance(accept),
        .hold_nx(hold_nx)
    );

    // Proportional term plus interpolated repetitive term
    always_comb begin
        wide_t prop_w;
        wide_t rep_w;
        prop_w = (wide_t'(kp_use) * wide_t'(err_in)) >>> FW;
        rep_w  = enable ? wide_t'(hold_nx) : wide_t'(0);
        ref_d  = to_dw(prop_w + rep_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ref_out <= '0;
        else if (smp_valid) ref_out <= ref_d;
    end

endmodule

// File: rtl/rptv_ctrl_chk.sv
module rptv_ctrl_chk
    import rptv_pkg::*;
#(
    parameter int DW  = 16,
    parameter int HW  = 18,
    parameter int KW  = 4,
    parameter int DEC = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enable,
    input logic                 smp_valid,
    input logic signed [DW-1:0] ref_out,
    input rptv_state_e          state,
    input logic [KW-1:0]        win,
    input logic signed [HW-1:0] hold_nx
);

    // R10: strobes are never back to back
    p_strobe_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    // R10: the strobe closing a window is followed by the update state
    p_update_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && smp_valid && win == KW'(DEC - 1)) |=> (state == ST_UPDATE));

    // R11: update lasts one clock and returns to gather
    p_update_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPDATE && enable) |=> (state == ST_GATHER || !enable));

    // R8: disable empties state and the repetitive contribution
    p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == ST_OFF && win == '0 && hold_nx == '0));

    // R1: output moves only after a strobe
    p_ref_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(ref_out));

    // R3: window position stays in range
    p_win_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win < KW'(DEC));

endmodule

bind rptv_ctrl rptv_ctrl_chk #(
    .DW (DW),
    .HW (HW),
    .KW (KW),
    .DEC(DEC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .smp_valid(smp_valid),
    .ref_out  (ref_out),
    .state    (state_q),
    .win      (win_q),
    .hold_nx  (hold_nx)
);

// File: tb/rptv_ctrl_tb.sv
module rptv_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NDEC = 10;
    localparam int LAG0 = 79;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [15:0] err_in = '0;
    logic signed [15:0] kp_in = '0;
    logic signed [15:0] krep_in = '0;
    logic signed [15:0] ref_out;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rptv_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .smp_valid(smp_valid),
        .err_in   (err_in),
        .kp_in    (kp_in),
        .krep_in  (krep_in),
        .ref_out  (ref_out)
    );

    int     total = 0;
    int     bad = 0;
    bit     done = 1'b0;
    string  tag = "R1 reset";

    // Behavioural reference state
    longint exp_ref = 0;
    longint kpl = 0, krl = 0, box = 0, hold = 0, slope = 0;
    int     wpos = 0;
    longint hist[$];

    function automatic longint sat(input longint x, input int w);
        longint hi;
        hi = (longint'(1) <<< (w - 1)) - 1;
        if (x > hi) return hi;
        if (x < -hi - 1) return -hi - 1;
        return x;
    endfunction

    function automatic longint past_v(input int lag);
        int idx;
        idx = hist.size() - lag;
        if (idx < 0) return 0;
        return hist[idx];
    endfunction

    task automatic model_clear();
        wpos = 0; box = 0; hold = 0; slope = 0;
        hist.delete();
    endtask

    task automatic model_sample(input longint e);
        longint m, f, v, tg;
        if (!enable) begin
            kpl = kp_in; krl = krep_in;
            exp_ref = sat((kpl * e) >>> 12, 16);
        end else begin
            if (wpos == 0) begin
                kpl = kp_in; krl = krep_in; box = e;
            end else begin
                box = box + e;
            end
            hold = sat(hold + slope, 18);
            exp_ref = sat(((kpl * e) >>> 12) + hold, 16);
            if (wpos == NDEC - 1) begin
                m  = (box * 6554) >>> 16;
                f  = ((past_v(LAG0) + past_v(LAG0 + 1) + past_v(LAG0 + 2)) * 21845) >>> 16;
                tg = sat((krl * past_v(LAG0 + 1)) >>> 12, 16);
                v  = sat(m + f, 24);
                hist.push_back(v);
                slope = sat(((tg - hold) * 6554) >>> 16, 18);
                wpos = 0;
            end else begin
                wpos++;
            end
        end
    endtask

    task automatic check_out();
        total++;
        if ($isunknown(ref_out) || longint'(ref_out) != exp_ref) begin
            bad++;
            $display("FAIL %s: ref_out=%0d expected=%0d", tag, ref_out, exp_ref);
        end
    endtask

    task automatic tick(input bit v, input int e);
        @(negedge clk);
        check_out();
        smp_valid = v;
        err_in = 16'(e);
        if (v) model_sample(longint'(signed'(16'(e))));
    endtask

    task automatic sample(input int e, input int gap);
        tick(1'b1, e);
        for (int g = 1; g < gap; g++) tick(1'b0, 0);
    endtask

    task automatic set_en(input bit en);
        tick(1'b0, 0);
        enable = en;
        if (!en) model_clear();
    endtask

    function automatic int wave(input int i);
        int p, t;
        p = i % 800;
        t = (p < 400) ? (p - 200) * 15 : (600 - p) * 15;
        if ((p % 160) < 8) t = t + 4000;
        return t;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1 reset";
        tick(1'b0, 0);
        tick(1'b0, 0);

        // Disabled: proportional only, with clamp at both ends
        tag = "R2 R8 R9 disabled proportional";
        kp_in = 16'sd4096;
        sample(1234, 3); sample(-1234, 3); sample(0, 3);
        kp_in = 16'sh7FFF;
        sample(32767, 3); sample(-32768, 3);
        kp_in = -16'sd4096;
        sample(-32768, 3); sample(32767, 3);
        kp_in = 16'sd1234;
        sample(777, 3);

        // Periodic error over three loop periods
        kp_in = 16'sd2048;
        krep_in = 16'sd8192;
        set_en(1'b1);
        tag = "R3 R4 R5 R6 R10 R11 periodic";
        for (int i = 0; i < 2400; i++) begin
            if (i == 1503) begin
                kp_in = 16'sd4096;
                tag = "R7 mid-window coefficient";
            end
            if (i == 1504) krep_in = 16'sd6000;
            if (i == 1530) tag = "R3 R4 R5 R6 periodic";
            sample(wave(i), 3);
        end

        // Disable, then restart with a large constant error
        set_en(1'b0);
        tag = "R8 disable clears";
        sample(5000, 3); sample(-5000, 3);
        kp_in = 16'sd1024;
        krep_in = 16'sh7FFF;
        set_en(1'b1);
        tag = "R8 R9 restart dc saturation";
        for (int i = 0; i < 1800; i++) sample(20000, 2);
        tag = "R9 negative drive";
        for (int i = 0; i < 1000; i++) sample(-20000, 2);
        tick(1'b0, 0);
        tick(1'b0, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: finished=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule